// File: doc/BRIEF.md
# Structure-Memory Request Flit Decoder

This block sits at the input of one structure-memory unit. It takes 16-bit flits from a shared bus, collects the two or three flits that make up one request, and turns each request into a fixed-width internal command made of a 4-bit operation code, a 12-bit address, a 16-bit data word and a 16-bit return-routing word. Finished commands wait in a small in-order queue that a downstream execution stage drains through a valid/ready handshake.

The first flit carries a unit-select bit in bit 15, a 2-bit unit number in bits 14:13, a 3-bit base opcode in bits 12:10, two shared bits in 9:8 and a low byte in 7:0. The two shared bits change meaning with the base opcode. When base bits 12 and 11 are both set, they extend the opcode to five bits and the low byte stands alone as the operand. Otherwise they are the top two bits of a 10-bit cell address. Requests for other units, and flits that are not structure-memory traffic, are swallowed whole so that the framing of the next request stays correct.

Top module: `flit_req_decoder`

## Requirements
- R1: After reset, `cmd_valid` and `illegal_op` are low and `flit_ready` is high.
- R2: For base opcodes 000 to 101, the internal code is the base opcode zero-extended to 4 bits. The address is {bits 9:8, bits 7:0} zero-extended to 12 bits.
- R3: For base opcodes 110 and 111, the internal code is 6 plus the 3-bit value {bit 10, bits 9:8}, giving 6 to 12. The address is bits 7:0 zero-extended to 12 bits.
- R4: In a 2-flit request, internal codes 1 (write) and 12 (immediate write) put flit 2 in `cmd_data`, with `cmd_route` zero. Every other 2-flit code puts flit 2 in `cmd_route`, with `cmd_data` zero.
- R5: Base opcode 101 marks a 3-flit request with internal code 5. Flit 2 goes to `cmd_data` and flit 3 to `cmd_route`. The address follows R2.
- R6: A request whose bit 15 is 0, or whose unit number differs from `UNIT_ID`, is consumed and queues nothing. It lasts three flits if bit 15 is 1 and the base opcode is 101, and two flits otherwise. The request that follows it decodes correctly.
- R7: A request on this unit with base opcode 111 and bits 9:8 equal to 11 queues nothing. It raises `illegal_op` for exactly one cycle, in the cycle after its second flit is accepted.
- R8: The queue holds `DEPTH` commands and returns them in arrival order. `flit_ready` is low exactly while the queue is full.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command outputs stay unchanged.
- R10: A command becomes visible on the outputs in the cycle after its last flit is accepted, provided the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_valid | input | 1 | A flit is offered on `flit_data` |
| flit_data | input | 16 | Incoming bus flit |
| flit_ready | output | 1 | The decoder accepts the offered flit |
| cmd_valid | output | 1 | A command sits at the head of the queue |
| cmd_ready | input | 1 | Downstream takes the head command |
| cmd_op | output | 4 | Internal operation code |
| cmd_addr | output | 12 | Zero-extended cell address or operand |
| cmd_data | output | 16 | Data word |
| cmd_route | output | 16 | Return-routing template |
| illegal_op | output | 1 | One-cycle pulse for the unused opcode |

## Verification
Every cycle, the assertions check the properties that follow from the ports alone:
- the queue never overflows, and `flit_ready` drops only when a command is waiting;
- a stalled head command holds steady;
- queued codes never exceed 12, and 5-bit-opcode commands never carry an address above 255;
- the illegal pulse never lasts two cycles.

Only the bench's scenarios can show the rest:
- that each opcode maps to the right code and address;
- that flit 2 and flit 3 land in the right field;
- that foreign and 3-flit requests keep the framing of the next request aligned;
- that commands leave the queue in arrival order.

// File: rtl/flit_req_decoder.sv
module flit_req_decoder #(
  parameter logic [1:0] UNIT_ID = 2'd1,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flit_valid,
  input  logic [15:0] flit_data,
  output logic        flit_ready,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [3:0]  cmd_op,
  output logic [11:0] cmd_addr,
  output logic [15:0] cmd_data,
  output logic [15:0] cmd_route,
  output logic        illegal_op
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = 48;

  typedef enum logic [1:0] {HDR, SECOND, THIRD} phase_t;
  phase_t phase;

  logic [3:0]  op_q;
  logic [11:0] addr_q;
  logic        keep_q, bad_q, long_q;
  logic [15:0] f2_q;

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] level;

  wire       wide   = flit_data[12] & flit_data[11];
  wire [2:0] xidx   = {flit_data[10], flit_data[9:8]};
  wire [3:0] dec_op = wide ? 4'd6 + {1'b0, xidx} : {1'b0, flit_data[12:10]};
  wire [11:0] dec_addr = wide ? {4'b0, flit_data[7:0]} : {2'b0, flit_data[9:0]};
  wire dec_long = flit_data[15] & ~wide & (flit_data[12:10] == 3'b101);
  wire dec_keep = flit_data[15] & (flit_data[14:13] == UNIT_ID);
  wire dec_bad  = wide & (xidx == 3'b111);

  wire accept = flit_valid & flit_ready;
  wire last   = (phase == THIRD) | (phase == SECOND & ~long_q);
  wire done   = accept & last;
  wire push   = done & keep_q & ~bad_q;
  wire pop    = cmd_valid & cmd_ready;
  wire wr_cls = (op_q == 4'd1) | (op_q == 4'd12);

  logic [15:0] new_data, new_route;
  always_comb begin
    if (phase == THIRD) begin
      new_data  = f2_q;
      new_route = flit_data;
    end else begin
      new_data  = wr_cls ? flit_data : 16'h0;
      new_route = wr_cls ? 16'h0 : flit_data;
    end
  end

  assign flit_ready = (level != CW'(DEPTH));
  assign cmd_valid  = (level != '0);
  assign {cmd_op, cmd_addr, cmd_data, cmd_route} = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= HDR;
      op_q       <= '0;
      addr_q     <= '0;
      keep_q     <= 1'b0;
      bad_q      <= 1'b0;
      long_q     <= 1'b0;
      f2_q       <= '0;
      illegal_op <= 1'b0;
    end else begin
      illegal_op <= done & keep_q & bad_q;
      if (accept) begin
        case (phase)
          HDR: begin
            op_q   <= dec_op;
            addr_q <= dec_addr;
            keep_q <= dec_keep;
            bad_q  <= dec_bad;
            long_q <= dec_long;
            phase  <= SECOND;
          end
          SECOND: begin
            f2_q  <= flit_data;
            phase <= long_q ? THIRD : HDR;
          end
          default: phase <= HDR;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {op_q, addr_q, new_data, new_route};
  end
endmodule

// File: rtl/flit_req_decoder_chk.sv
module flit_req_decoder_chk #(
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flit_ready,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [3:0]  cmd_op,
  input logic [11:0] cmd_addr,
  input logic [15:0] cmd_data,
  input logic [15:0] cmd_route,
  input logic        illegal_op,
  input logic [CW-1:0] level
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flit_ready |-> cmd_valid);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr)
      && $stable(cmd_data) && $stable(cmd_route));

  // R3
  op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op <= 4'd12);

  // R3
  short_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op >= 4'd6 |-> cmd_addr[11:8] == 4'h0);

  // R2
  addr_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr[11:10] == 2'b00);

  // R7
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> !illegal_op);
endmodule

bind flit_req_decoder flit_req_decoder_chk #(.DEPTH(DEPTH), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .flit_ready(flit_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .cmd_route(cmd_route), .illegal_op(illegal_op),
  .level(level)
);

// File: tb/flit_req_decoder_test.sv
`timescale 1ns/1ps
module flit_req_decoder_test;
  localparam int DEPTH = 4;
  localparam int NV = 18;

  logic clk = 0, rst_n = 0;
  logic flit_valid = 0, cmd_ready = 0;
  logic [15:0] flit_data = '0;
  logic flit_ready, cmd_valid, illegal_op;
  logic [3:0] cmd_op;
  logic [11:0] cmd_addr;
  logic [15:0] cmd_data, cmd_route;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flit_req_decoder #(.UNIT_ID(2'd1), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_data(flit_data),
    .flit_ready(flit_ready), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_route(cmd_route), .illegal_op(illegal_op));

  // {f1, f2, f3, nflits, cmd, illegal, op, addr, data, route}
  localparam logic [99:0] VEC [NV] = '{
    {16'hA3A5, 16'hBEEF, 16'h0, 2'd2, 1'b1, 1'b0, 4'd0,  12'h3A5, 16'h0,    16'hBEEF},
    {16'hA412, 16'h1234, 16'h0, 2'd2, 1'b1, 1'b0, 4'd1,  12'h012, 16'h1234, 16'h0},
    {16'hAAFF, 16'h0F0F, 16'h0, 2'd2, 1'b1, 1'b0, 4'd2,  12'h2FF, 16'h0,    16'h0F0F},
    {16'hAD00, 16'h1111, 16'h0, 2'd2, 1'b1, 1'b0, 4'd3,  12'h100, 16'h0,    16'h1111},
    {16'hB007, 16'h2222, 16'h0, 2'd2, 1'b1, 1'b0, 4'd4,  12'h007, 16'h0,    16'h2222},
    {16'hB880, 16'h3333, 16'h0, 2'd2, 1'b1, 1'b0, 4'd6,  12'h080, 16'h0,    16'h3333},
    {16'hB901, 16'h4444, 16'h0, 2'd2, 1'b1, 1'b0, 4'd7,  12'h001, 16'h0,    16'h4444},
    {16'hBA44, 16'h5151, 16'h0, 2'd2, 1'b1, 1'b0, 4'd8,  12'h044, 16'h0,    16'h5151},
    {16'hBB55, 16'h6161, 16'h0, 2'd2, 1'b1, 1'b0, 4'd9,  12'h055, 16'h0,    16'h6161},
    {16'hBC66, 16'h7171, 16'h0, 2'd2, 1'b1, 1'b0, 4'd10, 12'h066, 16'h0,    16'h7171},
    {16'hBD03, 16'h8181, 16'h0, 2'd2, 1'b1, 1'b0, 4'd11, 12'h003, 16'h0,    16'h8181},
    {16'hBE20, 16'h9191, 16'h0, 2'd2, 1'b1, 1'b0, 4'd12, 12'h020, 16'h9191, 16'h0},
    {16'hB73C, 16'hAAAA, 16'h5555, 2'd3, 1'b1, 1'b0, 4'd5, 12'h33C, 16'hAAAA, 16'h5555},
    {16'hC000, 16'hA412, 16'h0, 2'd2, 1'b0, 1'b0, 4'd0,  12'h0,   16'h0,    16'h0},
    {16'h2345, 16'hA412, 16'h0, 2'd2, 1'b0, 1'b0, 4'd0,  12'h0,   16'h0,    16'h0},
    {16'hF400, 16'hA412, 16'hA3A5, 2'd3, 1'b0, 1'b0, 4'd0, 12'h0, 16'h0,    16'h0},
    {16'hBFAB, 16'hA412, 16'h0, 2'd2, 1'b0, 1'b1, 4'd0,  12'h0,   16'h0,    16'h0},
    {16'hA001, 16'hCAFE, 16'h0, 2'd2, 1'b1, 1'b0, 4'd0,  12'h001, 16'h0,    16'hCAFE}
  };

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] f);
    @(negedge clk);
    flit_valid = 1'b1;
    flit_data = f;
    while (!flit_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle_bus();
    @(negedge clk);
    flit_valid = 1'b0;
  endtask

  task automatic pop();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] got, exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cmd_valid && flit_ready && !illegal_op, "R1",
          {45'b0, cmd_valid, flit_ready, illegal_op}, 48'b010);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      v = VEC[i];
      send(v[99:84]);
      send(v[83:68]);
      if (v[51:50] == 2'd3) send(v[67:52]);
      idle_bus();
      // R10: visible one cycle after last flit accepted
      if (v[49]) begin
        got = {cmd_op, cmd_addr, cmd_data, cmd_route};
        exp = v[47:0];
        check(cmd_valid, "R10", {47'b0, cmd_valid}, 48'b1);
        // R2 R3 R4 R5 decode fields
        check(got == exp, v[47:44] == 4'd5 ? "R5" : (v[47:44] >= 4'd6 ? "R3/R4" : "R2/R4"), got, exp);
        pop();
        check(!cmd_valid, "R8", {47'b0, cmd_valid}, 48'b0);
      end else begin
        // R6 / R7: nothing queued
        check(!cmd_valid, v[48] ? "R7" : "R6", {47'b0, cmd_valid}, 48'b0);
        check(illegal_op == v[48], "R7", {47'b0, illegal_op}, {47'b0, v[48]});
        @(negedge clk);
        check(!illegal_op, "R7", {47'b0, illegal_op}, 48'b0);
      end
    end

    // R8: fill the queue, ready drops, order preserved
    for (int k = 0; k < DEPTH; k++) begin
      send(16'hA400 | 16'(k));
      send(16'h0100 + 16'(k));
    end
    idle_bus();
    check(!flit_ready, "R8", {47'b0, flit_ready}, 48'b0);
    // R9: head holds while not taken
    exp = {cmd_op, cmd_addr, cmd_data, cmd_route};
    repeat (3) @(negedge clk);
    got = {cmd_op, cmd_addr, cmd_data, cmd_route};
    check(got == exp, "R9", got, exp);
    for (int k = 0; k < DEPTH; k++) begin
      got = {cmd_op, cmd_addr, cmd_data, cmd_route};
      exp = {4'd1, 12'(k), 16'h0100 + 16'(k), 16'h0};
      check(cmd_valid && got == exp, "R8", got, exp);
      pop();
      check(flit_ready, "R8", {47'b0, flit_ready}, 48'b1);
    end
    check(!cmd_valid, "R8", {47'b0, cmd_valid}, 48'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule